// File: doc/BRIEF.md
# SPI Register-Mapped 16-Pin Port Expander

This block is an SPI slave that gives a host control of sixteen general-purpose pins, grouped as two 8-bit halves, the low half and the high half. The host opens a frame by pulling chip select low. The first byte is a command, the second is a register address, and every later byte is register data. On a write, each data byte updates a register. On a read, each data byte clocks a register value out on MISO. After each data byte the register pointer moves on, so one frame can read or write a run of registers.

Each half has six kinds of register. The direction register sets which pins are inputs. The polarity register inverts the sensed value of input pins. The pull-up enable register drives an output of the block. The output latch sets the level that output pins drive. The port register returns the sensed pin level. The configuration register is shared by both halves. It selects between two address maps. In the paired map, the low-half and high-half registers of each kind sit at neighbouring addresses. In the split map, the high-half registers sit 0x10 above the low-half registers. The configuration register can also stop the pointer from advancing through the map. Pins that are inputs are not driven. The block provides drive enables and output values for the pad ring.

Top module: `gpx_expander`

## Requirements
- R1: After reset every direction bit is 1, so all pins are inputs and pin_oe is 0. The latch, polarity, pull-up and configuration registers are all 0. The paired map is active, and spi_miso is 0.
- R2: The command byte is 0x40 for a write and 0x41 for a read. Bit 0 is the read flag and bits 7:1 must equal 0x20. For any other command, the block ignores the rest of the frame: nothing is written and spi_miso stays 0.
- R3: The SPI link uses mode 0 and sends MSB first. MOSI is sampled on the rising SCK edge. MISO changes only after a falling SCK edge, except when the next read byte is loaded. The first bit of that byte is valid before the first rising edge of the data byte.
- R4: In the paired map (configuration bit 7 = 0), the low-half/high-half register addresses are as follows. Direction is 0x00/0x01, polarity 0x02/0x03, configuration 0x0A/0x0B, pull-up 0x0C/0x0D, port 0x12/0x13 and latch 0x14/0x15.
- R5: In the split map (configuration bit 7 = 1), the low-half registers are at direction 0x00, polarity 0x01, configuration 0x05, pull-up 0x06, port 0x09 and latch 0x0A. Each high-half register is at the same address plus 0x10.
- R6: The configuration register is a single register, reachable at both of its addresses. Bit 7 selects the split map and bit 5 disables sequencing. Bits 4:3 always read 0. Bits 6, 2, 1 and 0 are stored and read back.
- R7: When sequencing is enabled (bit 5 = 0), the pointer increments by one after every data byte.
- R8: When sequencing is disabled, the pointer behaviour depends on the map. In the paired map it toggles address bit 0, alternating between the two halves of one register pair. In the split map it stays on the same address.
- R9: pin_oe is the inverse of the direction register, and pin_out is the latch value. Reading a latch address returns the stored value.
- R10: A port read returns the sensed pin levels. Each bit is inverted only where both polarity and direction are 1. Writes to port addresses have no effect.
- R11: Any address not listed in R4 or R5 for the active map reads 0x00. Writes to such an address have no effect.
- R12: Raising chip select ends the frame. It discards any partly received byte, and the next frame starts again with a command byte.
- R13: A configuration write that changes the map applies from the next register decode. The pointer step that follows that same data byte still uses the old settings.
- R14: pullup_en carries the pull-up register: bits 7:0 are the low half and bits 15:8 are the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI inputs are oversampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| pin_in | input | 16 | Sensed pad levels, high half in bits 15:8 |
| pin_out | output | 16 | Output levels for the pads |
| pin_oe | output | 16 | Pad drive enables, 1 = driven |
| pullup_en | output | 16 | Pull-up enables for the pads |

## Verification
Two functions can fall in the same cycle: a configuration write that switches the map, and the pointer step that follows that byte. The bench provokes this with one paired-map write frame at 0x0A that carries two bytes. The first byte sets the split bit. The second byte must land on 0x0B, which is unmapped under the split map, so it must change nothing. This is judged at the ports: the per-clock comparison of the pin outputs, plus readbacks of the configuration and of 0x0B in later frames.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int GPX_BYTE_W   = 8;
    localparam int GPX_PIN_W    = 2 * GPX_BYTE_W;
    localparam int GPX_ADDR_W   = 8;
    localparam int CFG_SPLIT_B  = 7;
    localparam int CFG_NOSEQ_B  = 5;
    localparam logic [GPX_BYTE_W-1:0] CFG_KEEP = 8'hE7;

    typedef enum logic [2:0] {
        RK_NONE, RK_DIR, RK_POL, RK_CFG, RK_PULL, RK_PORT, RK_LATCH
    } reg_kind_e;

    typedef enum logic [1:0] {
        PH_OPCODE, PH_ADDR, PH_DATA, PH_SKIP
    } phase_e;
endpackage

// File: rtl/gpx_addr_map.sv
module gpx_addr_map
    import gpx_pkg::*;
#(
    parameter int ADDR_W = GPX_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              split,
    output reg_kind_e         kind,
    output logic              side_hi
);
    logic [3:0] offset;

    always_comb begin
        offset  = split ? addr[3:0] : addr[4:1];
        side_hi = split ? addr[4] : addr[0];
        kind    = RK_NONE;
        if (addr[ADDR_W-1:5] == '0) begin
            case (offset)
                4'd0:    kind = RK_DIR;
                4'd1:    kind = RK_POL;
                4'd5:    kind = RK_CFG;
                4'd6:    kind = RK_PULL;
                4'd9:    kind = RK_PORT;
                4'd10:   kind = RK_LATCH;
                default: kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpx_spi_shifter.sv
module gpx_spi_shifter #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              frame_active,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [2:0] SYNC_RST = 3'b010;   // {mosi, cs_n, sck}

    logic [2:0] sync_q [SYNC_STAGES];

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      sync_q[g] <= SYNC_RST;
                else if (g == 0) sync_q[g] <= {mosi, cs_n, sck};
                else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    logic sck_s, cs_s, mosi_s;
    assign {mosi_s, cs_s, sck_s} = sync_q[SYNC_STAGES-1];

    typedef struct packed {
        logic              prev_sck;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } shf_t;

    shf_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d          = st_q;
        st_d.prev_sck = sck_s;
        rise          = sck_s & ~st_q.prev_sck;
        fall          = ~sck_s & st_q.prev_sck;
        rx_byte       = {st_q.rx[BYTE_W-2:0], mosi_s};
        byte_done     = 1'b0;
        if (cs_s) begin
            st_d.cnt = '0;
            st_d.tx  = '0;
        end else begin
            if (rise) begin
                st_d.rx  = rx_byte;
                byte_done = (st_q.cnt == LAST_BIT);
                st_d.cnt = byte_done ? '0 : st_q.cnt + 1'b1;
            end
            if (fall && st_q.cnt != '0)
                st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
            if (tx_load)
                st_d.tx = tx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_active = ~cs_s;
    assign miso         = st_q.tx[BYTE_W-1];
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
    import gpx_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_CODE    = 7'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic [GPX_PIN_W-1:0] pin_in,
    output logic [GPX_PIN_W-1:0] pin_out,
    output logic [GPX_PIN_W-1:0] pin_oe,
    output logic [GPX_PIN_W-1:0] pullup_en
);
    localparam int BW = GPX_BYTE_W;
    localparam int PW = GPX_PIN_W;

    typedef struct packed {
        phase_e                phase;
        logic                  is_rd;
        logic [GPX_ADDR_W-1:0] ptr;
        logic [PW-1:0]         dir;
        logic [PW-1:0]         pol;
        logic [PW-1:0]         pull;
        logic [PW-1:0]         latch;
        logic [BW-1:0]         cfg;
        logic [PW-1:0]         pin_m;
        logic [PW-1:0]         pin_s;
    } exp_t;

    exp_t st_d, st_q;

    logic                  byte_done, frame_active, tx_load;
    logic [BW-1:0]         rx_byte, rd_val;
    logic [GPX_ADDR_W-1:0] ptr_step, rd_addr;
    logic [PW-1:0]         port_val;
    reg_kind_e             rd_kind, wr_kind;
    logic                  rd_hi, wr_hi;

    function automatic logic [BW-1:0] half_of(input logic [PW-1:0] v, input logic hi);
        return hi ? v[PW-1:BW] : v[BW-1:0];
    endfunction

    function automatic logic [PW-1:0] put_half(input logic [PW-1:0] v, input logic hi,
                                               input logic [BW-1:0] b);
        return hi ? {b, v[BW-1:0]} : {v[PW-1:BW], b};
    endfunction

    gpx_spi_shifter #(.BYTE_W(BW), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck          (spi_sck),
        .cs_n         (spi_cs_n),
        .mosi         (spi_mosi),
        .tx_load      (tx_load),
        .tx_byte      (rd_val),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .frame_active (frame_active),
        .miso         (spi_miso)
    );

    gpx_addr_map u_rd_map (
        .addr    (rd_addr),
        .split   (st_q.cfg[CFG_SPLIT_B]),
        .kind    (rd_kind),
        .side_hi (rd_hi)
    );

    gpx_addr_map u_wr_map (
        .addr    (st_q.ptr),
        .split   (st_q.cfg[CFG_SPLIT_B]),
        .kind    (wr_kind),
        .side_hi (wr_hi)
    );

    always_comb begin
        st_d       = st_q;
        tx_load    = 1'b0;
        st_d.pin_m = pin_in;
        st_d.pin_s = st_q.pin_m;

        if (!st_q.cfg[CFG_NOSEQ_B])      ptr_step = st_q.ptr + 1'b1;
        else if (!st_q.cfg[CFG_SPLIT_B]) ptr_step = st_q.ptr ^ GPX_ADDR_W'(1);
        else                             ptr_step = st_q.ptr;

        rd_addr  = (st_q.phase == PH_ADDR) ? rx_byte : ptr_step;
        port_val = st_q.pin_s ^ (st_q.pol & st_q.dir);

        case (rd_kind)
            RK_DIR:   rd_val = half_of(st_q.dir, rd_hi);
            RK_POL:   rd_val = half_of(st_q.pol, rd_hi);
            RK_CFG:   rd_val = st_q.cfg;
            RK_PULL:  rd_val = half_of(st_q.pull, rd_hi);
            RK_PORT:  rd_val = half_of(port_val, rd_hi);
            RK_LATCH: rd_val = half_of(st_q.latch, rd_hi);
            default:  rd_val = '0;
        endcase

        if (!frame_active) begin
            st_d.phase = PH_OPCODE;
        end else if (byte_done) begin
            case (st_q.phase)
                PH_OPCODE: begin
                    if (rx_byte[BW-1:1] == DEV_CODE) begin
                        st_d.phase = PH_ADDR;
                        st_d.is_rd = rx_byte[0];
                    end else begin
                        st_d.phase = PH_SKIP;
                    end
                end
                PH_ADDR: begin
                    st_d.ptr   = rx_byte;
                    st_d.phase = PH_DATA;
                    tx_load    = st_q.is_rd;
                end
                PH_DATA: begin
                    st_d.ptr = ptr_step;
                    tx_load  = st_q.is_rd;
                    if (!st_q.is_rd) begin
                        case (wr_kind)
                            RK_DIR:   st_d.dir   = put_half(st_q.dir, wr_hi, rx_byte);
                            RK_POL:   st_d.pol   = put_half(st_q.pol, wr_hi, rx_byte);
                            RK_PULL:  st_d.pull  = put_half(st_q.pull, wr_hi, rx_byte);
                            RK_LATCH: st_d.latch = put_half(st_q.latch, wr_hi, rx_byte);
                            RK_CFG:   st_d.cfg   = rx_byte & CFG_KEEP;
                            default:  ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OPCODE;
            st_q.dir   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out   = st_q.latch;
    assign pin_oe    = ~st_q.dir;
    assign pullup_en = st_q.pull;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spi_sck,
    input logic                 spi_cs_n,
    input logic                 spi_miso,
    input logic [GPX_PIN_W-1:0] pin_out,
    input logic [GPX_PIN_W-1:0] pin_oe,
    input logic [GPX_PIN_W-1:0] pullup_en
);
    AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);  // R12

    AST_MISO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck, 1) && $past(spi_sck, 2) && $past(spi_sck, 3) && $past(spi_sck, 4)
         && !spi_cs_n && !$past(spi_cs_n, 1) && !$past(spi_cs_n, 4))
        |-> $stable(spi_miso));  // R3

    AST_PIN_CHANGE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pin_out) || !$stable(pin_oe) || !$stable(pullup_en))
        |-> ($past(spi_sck, 3) && !$past(spi_sck, 4) && !$past(spi_cs_n, 3)));  // R9

    AST_IDLE_PINS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> ($stable(pin_out) && $stable(pin_oe) && $stable(pullup_en)));  // R12
endmodule

bind gpx_expander gpx_checker u_gpx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pullup_en (pullup_en)
);

// File: tb/gpx_expander_test.sv
module gpx_expander_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] pins = 16'h0000;
    logic [15:0] pin_out, pin_oe, pullup_en;

    always #5 clk = ~clk;

    gpx_expander uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .pin_in    (pins),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pullup_en (pullup_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_on   = 1'b0;

    logic [15:0] m_dir  = 16'hFFFF;
    logic [15:0] m_pol  = 16'h0000;
    logic [15:0] m_pull = 16'h0000;
    logic [15:0] m_lat  = 16'h0000;
    logic [7:0]  m_cfg  = 8'h00;

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // kinds: 0 none, 1 dir, 2 pol, 3 cfg, 4 pull, 5 port, 6 latch
    function automatic int m_kind(input logic [7:0] a, output bit hi);
        int k;
        if (!m_cfg[7]) begin
            hi = a[0];
            case (a)
                8'h00, 8'h01: k = 1;
                8'h02, 8'h03: k = 2;
                8'h0A, 8'h0B: k = 3;
                8'h0C, 8'h0D: k = 4;
                8'h12, 8'h13: k = 5;
                8'h14, 8'h15: k = 6;
                default:      k = 0;
            endcase
        end else begin
            hi = a[4];
            case (a)
                8'h00, 8'h10: k = 1;
                8'h01, 8'h11: k = 2;
                8'h05, 8'h15: k = 3;
                8'h06, 8'h16: k = 4;
                8'h09, 8'h19: k = 5;
                8'h0A, 8'h1A: k = 6;
                default:      k = 0;
            endcase
        end
        return k;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        bit hi;
        int k;
        logic [15:0] v;
        k = m_kind(a, hi);
        case (k)
            1: v = m_dir;
            2: v = m_pol;
            3: return m_cfg;
            4: v = m_pull;
            5: v = pins ^ (m_pol & m_dir);
            6: v = m_lat;
            default: return 8'h00;
        endcase
        return hi ? v[15:8] : v[7:0];
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [7:0] b);
        bit hi;
        int k;
        k = m_kind(a, hi);
        case (k)
            1: if (hi) m_dir[15:8]  = b; else m_dir[7:0]  = b;
            2: if (hi) m_pol[15:8]  = b; else m_pol[7:0]  = b;
            3: m_cfg = b & 8'hE7;
            4: if (hi) m_pull[15:8] = b; else m_pull[7:0] = b;
            6: if (hi) m_lat[15:8]  = b; else m_lat[7:0]  = b;
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] m_step(input logic [7:0] a);
        if (!m_cfg[5]) return a + 8'd1;
        if (!m_cfg[7]) return a ^ 8'h01;
        return a;
    endfunction

    // Last bit returns three clock edges after the rising SCK edge.
    task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            got[i] = miso;
            sck = 1'b1;
            repeat (3) @(posedge clk);
            if (i > 8 - nbits) repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic hold_high();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic start_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk);
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] opc, input logic [7:0] addr, input int nb,
                         input string tag, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2);
        logic [7:0] got, expb, ptr, nxt, b;
        logic [7:0] wd [3];
        bit dev, rd;
        wd[0] = b0; wd[1] = b1; wd[2] = b2;
        start_frame();
        xfer(opc, 8, got);
        dev = (opc[7:1] == 7'h20);
        rd  = opc[0];
        hold_high();
        xfer(addr, 8, got);
        ptr  = addr;
        expb = (dev && rd) ? m_read(ptr) : 8'h00;
        hold_high();
        for (int i = 0; i < nb; i++) begin
            b = (!rd && i < 3) ? wd[i] : 8'h00;
            xfer(b, 8, got);
            chk(tag, {40'd0, got}, {40'd0, expb});
            if (dev) begin
                nxt = m_step(ptr);
                if (!rd) m_write(ptr, b);
                ptr = nxt;
            end
            expb = (dev && rd) ? m_read(ptr) : 8'h00;
            hold_high();
        end
        end_frame();
    endtask

    task automatic abort_frame();
        logic [7:0] got;
        start_frame();
        xfer(8'h40, 8, got);
        hold_high();
        xfer(8'h1A, 8, got);
        hold_high();
        xfer(8'hFF, 4, got);
        end_frame();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // R9 R14: pad-side outputs against the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            n_checks++;
            if ({pin_out, pin_oe, pullup_en} !== {m_lat, ~m_dir, m_pull}) begin
                n_fail++;
                $display("FAIL R9 R14 pin state actual=%h expected=%h",
                         {pin_out, pin_oe, pullup_en}, {m_lat, ~m_dir, m_pull});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {pin_out, pin_oe, pullup_en}, 48'h0);
        chk("R1 reset miso", {47'd0, miso}, 48'd0);
        cmp_on = 1'b1;

        frame(8'h41, 8'h00, 2, "R1 R4 direction reset read", 0, 0, 0);
        frame(8'h41, 8'h0A, 1, "R1 R6 config reset read", 0, 0, 0);
        frame(8'h40, 8'h14, 2, "R7 R9 latch pair write", 8'hA5, 8'h3C, 0);
        frame(8'h40, 8'h00, 2, "R4 R9 direction write", 8'h0F, 8'hF0, 0);
        frame(8'h41, 8'h14, 3, "R3 R7 R11 latch read past end", 0, 0, 0);

        pins = 16'h5AC3;
        frame(8'h40, 8'h02, 2, "R10 polarity write", 8'hFF, 8'hFF, 0);
        frame(8'h41, 8'h12, 2, "R10 port read with polarity", 0, 0, 0);
        frame(8'h40, 8'h0C, 2, "R14 pull-up write", 8'h12, 8'h34, 0);
        frame(8'h41, 8'h0C, 2, "R4 R14 pull-up read", 0, 0, 0);

        frame(8'h40, 8'h0A, 1, "R6 config write reserved", 8'h3F, 0, 0);
        frame(8'h41, 8'h0B, 3, "R6 R8 config toggle read", 0, 0, 0);
        frame(8'h40, 8'h14, 3, "R8 paired toggle write", 8'h11, 8'h22, 8'h33);
        frame(8'h41, 8'h14, 2, "R8 paired toggle read", 0, 0, 0);
        frame(8'h40, 8'h0A, 1, "R6 sequencing back on", 8'h00, 0, 0);

        frame(8'h40, 8'h0A, 2, "R13 map switch in frame", 8'h80, 8'h55, 0);
        frame(8'h41, 8'h05, 1, "R5 R13 split config read", 0, 0, 0);
        frame(8'h41, 8'h0B, 1, "R11 R13 split unmapped read", 0, 0, 0);
        frame(8'h41, 8'h0A, 2, "R5 split low latch read", 0, 0, 0);
        frame(8'h41, 8'h1A, 1, "R5 split high latch read", 0, 0, 0);
        frame(8'h40, 8'h16, 1, "R5 split high pull-up write", 8'h77, 0, 0);
        frame(8'h41, 8'h00, 2, "R5 R7 split direction then polarity", 0, 0, 0);
        frame(8'h40, 8'h05, 1, "R8 split hold config", 8'hA0, 0, 0);
        frame(8'h40, 8'h1A, 3, "R8 split hold write", 8'h01, 8'h02, 8'h03);
        frame(8'h41, 8'h1A, 2, "R8 split hold read", 0, 0, 0);

        frame(8'h40, 8'h04, 1, "R11 unmapped write", 8'hFF, 0, 0);
        frame(8'h40, 8'h09, 1, "R10 port write ignored", 8'hFF, 0, 0);
        frame(8'h41, 8'h04, 1, "R11 unmapped read", 0, 0, 0);
        frame(8'h41, 8'h09, 1, "R10 port read split", 0, 0, 0);

        frame(8'h42, 8'h1A, 1, "R2 foreign write ignored", 8'h55, 0, 0);
        frame(8'h43, 8'h1A, 1, "R2 foreign read silent", 0, 0, 0);
        frame(8'h41, 8'h1A, 1, "R2 latch after foreign", 0, 0, 0);

        abort_frame();
        frame(8'h41, 8'h1A, 1, "R12 read after abort", 0, 0, 0);
        frame(8'h40, 8'h05, 1, "R6 back to paired map", 8'h00, 0, 0);
        frame(8'h41, 8'h0A, 2, "R4 R6 paired config read", 0, 0, 0);

        cmp_on = 1'b0;
        summary();
        $finish;
    end
endmodule